// File: doc/BRIEF.md
# Transmit Automatic Level Controller

This block sets the attenuation of a stepped transmit gain stage. A feedback path, which lies outside the block, measures the AC peak of the transmitted signal. Two comparators report it to the block as two flags: `peak_low` is set while the peak sits under the lower threshold, and `peak_high` is set while it sits over the upper threshold. The controller turns these flags into a 3-bit attenuation code. Each code unit is worth 3 dB, so codes 0 to 7 span 0 to 21 dB.

Adaptation runs only at the head of each transmitted frame. A frame-start pulse arms the controller. After that, the quarter-bit strobe, which pulses four times per data bit, triggers one step decision per pulse. After eight decisions, which is the first two bits of the frame, the code is frozen and `adapt_done` is raised. The frozen code is held for the rest of the frame. It is also the starting point for the next frame's adaptation. Reset puts the stage at maximum attenuation, so the first frame starts quietly and works its way up.

Top module: `tx_alc_ctrl`

## Requirements
- R1: After reset, `atten_code` is 7 (maximum attenuation, 21 dB) and `adapt_done` is 0.
- R2: On an adaptation step with `peak_low`=1 and `peak_high`=0, the code decreases by exactly 1, which is 3 dB less attenuation and so more gain.
- R3: On an adaptation step with `peak_high`=1 and `peak_low`=0, the code increases by exactly 1, which is 3 dB more attenuation and so less gain.
- R4: On an adaptation step where both flags are 0, or both are 1, the code is unchanged.
- R5: The code saturates. A decrease at code 0 leaves it at 0, and an increase at code 7 leaves it at 7.
- R6: A step uses the flag values registered on the clock edge before the strobe cycle. Flag values present only during the strobe cycle itself have no effect on that step.
- R7: Exactly eight steps follow each frame-start pulse, one per `qtr_bit_stb` pulse. `adapt_done` rises at the same clock edge that applies the eighth step.
- R8: Strobes before the first frame start, or after the eighth step of a frame, leave the code unchanged.
- R9: A frame-start pulse clears `adapt_done` at the next clock edge. It does not reset the code, so the code carries over from the previous frame.
- R10: A strobe in the same cycle as a frame-start pulse is ignored. The eight steps of the new frame are counted from the strobes that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | One-cycle pulse that marks the start of a new transmit frame |
| qtr_bit_stb | input | 1 | One-cycle strobe, four pulses per data bit |
| peak_low | input | 1 | Feedback peak is below the lower threshold |
| peak_high | input | 1 | Feedback peak is above the upper threshold |
| atten_code | output | 3 | Attenuation code, 3 dB per unit |
| adapt_done | output | 1 | The eight steps of the current frame have been applied |

## Verification
The flags must be present one clock before a strobe cycle, because they pass through one register. The code and `adapt_done` then change at the clock edge that ends the strobe cycle, and `adapt_done` falls at the edge that ends the frame-start cycle. The bench drives every input on the falling edge. It holds the flags for a full cycle before raising the strobe, and it reads the outputs on the falling edge that follows the strobe or frame-start cycle. Each check therefore lands exactly one register stage after the stimulus that causes it. To cover the one-cycle flag delay (R6), a scenario swaps the flags inside the strobe cycle and expects the earlier values to win.

// File: rtl/tx_alc_pkg.sv
package tx_alc_pkg;

  typedef enum logic [1:0] {
    ALC_HOLD = 2'd0,
    ALC_LESS = 2'd1,   // lower attenuation, raise gain
    ALC_MORE = 2'd2    // raise attenuation, lower gain
  } alc_dir_e;

  // Map the comparator pair to a step direction; equal flags mean hold.
  function automatic alc_dir_e decide_dir(input logic below_lo, input logic above_hi);
    if (below_lo && !above_hi)      return ALC_LESS;
    else if (above_hi && !below_lo) return ALC_MORE;
    else                            return ALC_HOLD;
  endfunction

  // Apply one saturating step to the attenuation code.
  function automatic int unsigned apply_dir(input int unsigned cur,
                                            input int unsigned top,
                                            input alc_dir_e    dir);
    case (dir)
      ALC_LESS: return (cur == 0)   ? cur : cur - 1;
      ALC_MORE: return (cur >= top) ? top : cur + 1;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/alc_flag_reg.sv
module alc_flag_reg #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] pipe [STAGES+1];

  assign pipe[0] = d_in;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s+1] <= '0;
      else        pipe[s+1] <= pipe[s];
    end
  end

  assign q_out = pipe[STAGES];

endmodule

// File: rtl/alc_step_seq.sv
module alc_step_seq #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic qtr_stb,
  output logic step_en,
  output logic step_last,
  output logic done
);

  localparam int CNT_W = $clog2(STEPS + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  // A strobe coinciding with frame start belongs to no window.
  assign step_en   = active_q && qtr_stb && !frame_start;
  assign step_last = step_en && (cnt_q == CNT_W'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else if (frame_start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      done     <= 1'b0;
    end else if (step_en) begin
      cnt_q <= cnt_q + 1'b1;
      if (step_last) begin
        active_q <= 1'b0;
        done     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/alc_code_reg.sv
module alc_code_reg
  import tx_alc_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              below_lo,
  input  logic              above_hi,
  output logic [CODE_W-1:0] code
);

  localparam int unsigned TOP_CODE = (1 << CODE_W) - 1;

  alc_dir_e dir;
  assign dir = decide_dir(below_lo, above_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= CODE_W'(TOP_CODE);
    else if (step_en) code <= CODE_W'(apply_dir(int'(code), TOP_CODE, dir));
  end

endmodule

// File: rtl/tx_alc_ctrl.sv
module tx_alc_ctrl #(
  parameter int CODE_W      = 3,
  parameter int STEPS       = 8,
  parameter int FLAG_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              qtr_bit_stb,
  input  logic              peak_low,
  input  logic              peak_high,
  output logic [CODE_W-1:0] atten_code,
  output logic              adapt_done
);

  logic [1:0] flags_q;
  logic       lo_q;
  logic       hi_q;
  logic       step_en;
  logic       step_last;

  alc_flag_reg #(.WIDTH(2), .STAGES(FLAG_STAGES)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({peak_high, peak_low}),
    .q_out (flags_q)
  );

  assign lo_q = flags_q[0];
  assign hi_q = flags_q[1];

  alc_step_seq #(.STEPS(STEPS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .qtr_stb     (qtr_bit_stb),
    .step_en     (step_en),
    .step_last   (step_last),
    .done        (adapt_done)
  );

  alc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .below_lo (lo_q),
    .above_hi (hi_q),
    .code     (atten_code)
  );

endmodule

// File: rtl/tx_alc_ctrl_chk.sv
module tx_alc_ctrl_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              step_en,
  input logic              step_last,
  input logic              lo_q,
  input logic              hi_q,
  input logic [CODE_W-1:0] atten_code,
  input logic              adapt_done
);

  localparam logic [CODE_W-1:0] TOP = '1;

  // R2: one unit less attenuation on a low-peak step
  p_less_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && lo_q && !hi_q && atten_code != '0 |=> atten_code == $past(atten_code) - 1'b1);

  // R3: one unit more attenuation on a high-peak step
  p_more_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && hi_q && !lo_q && atten_code != TOP |=> atten_code == $past(atten_code) + 1'b1);

  // R4: equal flags hold the code
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (lo_q == hi_q) |=> $stable(atten_code));

  // R5: saturation at both ends
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && lo_q && !hi_q && atten_code == '0 |=> atten_code == '0);
  p_ceil_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && hi_q && !lo_q && atten_code == TOP |=> atten_code == TOP);

  // R8: the code moves only on a step
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(atten_code));

  // R7: done rises only from the last step
  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adapt_done) |-> $past(step_last));

  // R9: frame start clears done
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !adapt_done);

  // R10: no step in a frame-start cycle
  p_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !step_en);

endmodule

bind tx_alc_ctrl tx_alc_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .step_en     (step_en),
  .step_last   (step_last),
  .lo_q        (lo_q),
  .hi_q        (hi_q),
  .atten_code  (atten_code),
  .adapt_done  (adapt_done)
);

// File: tb/tx_alc_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_alc_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       qtr_bit_stb = 1'b0;
  logic       peak_low = 1'b0;
  logic       peak_high = 1'b0;
  logic [2:0] atten_code;
  logic       adapt_done;

  int vectors = 0;
  int errors  = 0;
  int model   = 7;

  always #4 clk = ~clk;

  tx_alc_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .qtr_bit_stb (qtr_bit_stb),
    .peak_low    (peak_low),
    .peak_high   (peak_high),
    .atten_code  (atten_code),
    .adapt_done  (adapt_done)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_step(input int cur, input bit lo, input bit hi);
    if (lo && !hi) return (cur > 0) ? cur - 1 : 0;
    if (hi && !lo) return (cur < 7) ? cur + 1 : 7;
    return cur;
  endfunction

  // Flags held a full cycle, then strobe; flags_now apply only during strobe.
  task automatic step(input bit lo, input bit hi, input bit lo_now, input bit hi_now);
    @(negedge clk); peak_low = lo; peak_high = hi;
    @(negedge clk); qtr_bit_stb = 1'b1; peak_low = lo_now; peak_high = hi_now;
    @(negedge clk); qtr_bit_stb = 1'b0;
  endtask

  task automatic start_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 code after reset", atten_code, 7);
    check("R1 done after reset", adapt_done, 0);
  endtask

  task automatic t_idle_strobes();
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    check("R8 strobe before any frame", atten_code, 7);
  endtask

  task automatic t_low_run();
    start_frame();
    check("R9 done low after frame start", adapt_done, 0);
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 1, 0);
      model = ref_step(model, 1, 0);
      check(i == 7 ? "R5 floor saturation" : "R2 step down", atten_code, model);
      check("R7 done timing", adapt_done, (i == 7) ? 1 : 0);
    end
    step(0, 1, 0, 1);
    check("R8 strobe after eighth step", atten_code, model);
    check("R7 done held", adapt_done, 1);
  endtask

  task automatic t_high_run();
    start_frame();
    check("R9 done cleared by frame start", adapt_done, 0);
    check("R9 code carried over", atten_code, model);
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 0, 1);
      model = ref_step(model, 0, 1);
      check(i == 7 ? "R5 ceiling saturation" : "R3 step up", atten_code, model);
    end
    check("R7 done after eight", adapt_done, 1);
  endtask

  task automatic t_mixed();
    bit lo_v [8] = '{1, 1, 0, 1, 1, 0, 0, 1};
    bit hi_v [8] = '{0, 1, 0, 0, 0, 1, 1, 1};
    start_frame();
    for (int i = 0; i < 8; i++) begin
      step(lo_v[i], hi_v[i], lo_v[i], hi_v[i]);
      model = ref_step(model, lo_v[i], hi_v[i]);
      check((lo_v[i] == hi_v[i]) ? "R4 hold on equal flags" : "R2/R3 mixed step",
            atten_code, model);
    end
  endtask

  task automatic t_flag_timing();
    start_frame();
    step(1, 0, 0, 1);
    model = ref_step(model, 1, 0);
    check("R6 registered flag used", atten_code, model);
    step(0, 1, 1, 0);
    model = ref_step(model, 0, 1);
    check("R6 registered flag used", atten_code, model);
  endtask

  task automatic t_collision();
    @(negedge clk); peak_low = 1'b1; peak_high = 1'b0;
    @(negedge clk); frame_start = 1'b1; qtr_bit_stb = 1'b1;
    @(negedge clk); frame_start = 1'b0; qtr_bit_stb = 1'b0;
    check("R10 strobe with frame start ignored", atten_code, model);
    check("R10 done low", adapt_done, 0);
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 1, 0);
      model = ref_step(model, 1, 0);
      check("R10 eight later steps", atten_code, model);
      check("R10 done count", adapt_done, (i == 7) ? 1 : 0);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_strobes();
    t_low_run();
    t_high_run();
    t_mixed();
    t_flag_timing();
    t_collision();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule